// File: doc/BRIEF.md
# Machine Cycle, Retire and Event Counters

This block keeps the machine-level performance counters of a processor hart: a free-running cycle counter, a retired-instruction counter and a configurable number of event counters. Every counter is 64 bits wide. Software reaches each counter through two 32-bit CSR addresses, one for the low half and one for the high half. A 32-bit inhibit register sits beside them and holds one stop bit per counter.

The pipeline reports each completing instruction with `ret_valid`. It raises `ret_fault` when that instruction ended in an exception, for example an illegal-instruction trap. A faulting instruction is never counted as retired. Event counters count pulses on `evt_i`. The `RETIRE_EVT` parameter marks which events also need a clean retire in the same cycle. A CSR access drives address, data and write enable for one cycle. Read data comes back combinationally and shows the state before that cycle's update. A write lands at the clock edge that ends the writing instruction. The written value replaces that cycle's increment, and a new inhibit setting governs only the cycles that follow.

Top module: `mctr_unit`

## Requirements
- R1: The cycle counter (index 0, low half at 0xB00, high half at 0xB80) increases by one on every clock while inhibit bit 0 is clear, and holds while that bit is set.
- R2: The retire counter (index 2, at 0xB02/0xB82) increases by one in each cycle with `ret_valid`=1 and `ret_fault`=0 while inhibit bit 2 is clear, and holds while that bit is set.
- R3: A cycle with `ret_valid`=1 and `ret_fault`=1 changes neither the retire counter nor any event counter whose `RETIRE_EVT` bit is set.
- R4: Event counter k (index 3+k, at 0xB03+k/0xB83+k) increases by one in each cycle where `evt_i[k]`=1 and inhibit bit 3+k is clear. If `RETIRE_EVT[k]`=1, a clean retire in the same cycle is also required.
- R5: Each counter is 64 bits. The low half is read at 0xB00+index and the high half at 0xB80+index. A carry out of the low half reaches the high half in the same cycle as the increment.
- R6: Writing one half replaces only that half and leaves the other half unchanged. When a write and an increment hit the same counter in one cycle, the counter takes the written value and the increment is dropped.
- R7: A write to the inhibit register (0x320) takes effect from the next cycle. The increments of the writing cycle use the old setting.
- R8: Only inhibit bits 0, 2 and 3..2+NUM_HPM can be written. Every other inhibit bit always reads as zero.
- R9: An inhibited counter can still be read and written.
- R10: A counter address of index 1, or of index 3+NUM_HPM or higher, reads as zero and raises `csr_illegal` while `csr_en`=1. Addresses outside the two counter windows and 0x320 read as zero with `csr_illegal`=0.
- R11: After a synchronous reset, every counter is zero and the inhibit register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ret_valid | input | 1 | An instruction completes this cycle |
| ret_fault | input | 1 | The completing instruction raised an exception |
| evt_i | input | max(NUM_HPM,1) | Event pulses, one per event counter |
| csr_en | input | 1 | CSR access this cycle |
| csr_we | input | 1 | The access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data (state before this cycle's update) |
| csr_illegal | output | 1 | Access to an unimplemented counter address |

## Verification
The bound checker checks three things on every cycle. The cycle counter steps by one while it is enabled. The retire counter stays frozen on a faulting retire or while its inhibit bit is set. A low-half write lands exactly as written. The checker also confirms that inhibit reads never show bits outside the legal mask and that an illegal access reads as zero.

Only the bench scenarios can show the other behaviours. These are the carry into the high half, the one-cycle lag of an inhibit change (a retire in the cycle that clears the stop bit is not counted), event qualification by retire, and the read-zero behaviour for each unimplemented index. The bench compares these against its own cycle-level model.

// File: rtl/mctr_pkg.sv
package mctr_pkg;

    localparam int CSR_AW = 12;
    localparam int XW     = 32;
    localparam int CW     = 64;
    localparam int NIDX   = 32;

    localparam int IDX_CYCLE   = 0;
    localparam int IDX_INSTRET = 2;
    localparam int IDX_HPM0    = 3;

    localparam logic [CSR_AW-1:0] ADDR_INHIBIT = 12'h320;
    localparam logic [6:0]        WIN_LO       = 7'b1011000;   // 0xB00..0xB1F
    localparam logic [6:0]        WIN_HI       = 7'b1011100;   // 0xB80..0xB9F

    typedef struct packed {
        logic       win;     // address falls in a counter window
        logic       hi;      // upper half selected
        logic [4:0] idx;     // counter index
        logic       impl;    // index is implemented
        logic       inh;     // inhibit register selected
    } csr_dec_t;

    function automatic logic idx_impl(input int idx, input int n_hpm);
        return (idx == IDX_CYCLE) || (idx == IDX_INSTRET) ||
               (idx >= IDX_HPM0 && idx < IDX_HPM0 + n_hpm);
    endfunction

    function automatic logic [XW-1:0] inhibit_mask(input int n_hpm);
        logic [XW-1:0] m;
        m = '0;
        for (int b = 0; b < XW; b++) m[b] = idx_impl(b, n_hpm);
        return m;
    endfunction

endpackage

// File: rtl/mctr_decode.sv
module mctr_decode
    import mctr_pkg::*;
#(
    parameter int NUM_HPM = 3
) (
    input  logic [CSR_AW-1:0] addr,
    output csr_dec_t          dec
);
    always_comb begin
        dec.win  = (addr[11:5] == WIN_LO) || (addr[11:5] == WIN_HI);
        dec.hi   = addr[7];
        dec.idx  = addr[4:0];
        dec.impl = idx_impl(int'(addr[4:0]), NUM_HPM);
        dec.inh  = (addr == ADDR_INHIBIT);
    end
endmodule

// File: rtl/mctr_counter.sv
module mctr_counter
    import mctr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [XW-1:0] wdata,
    output logic [CW-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst)        value <= '0;
        else if (wr_lo) value <= {value[CW-1:XW], wdata};
        else if (wr_hi) value <= {wdata, value[XW-1:0]};
        else if (inc)   value <= value + CW'(1);
    end
endmodule

// File: rtl/mctr_inhibit.sv
module mctr_inhibit
    import mctr_pkg::*;
#(
    parameter int NUM_HPM = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [XW-1:0] wdata,
    output logic [XW-1:0] q
);
    localparam logic [XW-1:0] MASK = inhibit_mask(NUM_HPM);

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= wdata & MASK;
    end
endmodule

// File: rtl/mctr_unit.sv
module mctr_unit
    import mctr_pkg::*;
#(
    parameter int          NUM_HPM    = 3,
    parameter logic [28:0] RETIRE_EVT = 29'h1,
    localparam int         EVT_W      = (NUM_HPM > 0) ? NUM_HPM : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ret_valid,
    input  logic              ret_fault,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic              csr_en,
    input  logic              csr_we,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [XW-1:0]     csr_wdata,
    output logic [XW-1:0]     csr_rdata,
    output logic              csr_illegal
);
    csr_dec_t      dec;
    logic          clean_ret;
    logic          wr_any;
    logic [XW-1:0] inh_q;
    logic [CW-1:0] cnt_q [NIDX];

    mctr_decode #(.NUM_HPM(NUM_HPM)) dec_i (.addr(csr_addr), .dec(dec));

    assign clean_ret = ret_valid & ~ret_fault;
    assign wr_any    = csr_en & csr_we;

    mctr_inhibit #(.NUM_HPM(NUM_HPM)) inh_i (
        .clk(clk), .rst(rst), .we(wr_any & dec.inh),
        .wdata(csr_wdata), .q(inh_q)
    );

    for (genvar i = 0; i < NIDX; i++) begin : g_cnt
        logic sel, src;
        assign sel = wr_any & dec.win & (dec.idx == 5'(i));
        if (i == IDX_CYCLE) begin : g_cyc
            assign src = 1'b1;
        end else if (i == IDX_INSTRET) begin : g_ret
            assign src = clean_ret;
        end else if (i >= IDX_HPM0 && i < IDX_HPM0 + NUM_HPM) begin : g_hpm
            assign src = evt_i[i-IDX_HPM0] & (RETIRE_EVT[i-IDX_HPM0] ? clean_ret : 1'b1);
        end else begin : g_none
            assign src = 1'b0;
        end

        if (idx_impl(i, NUM_HPM)) begin : g_impl
            mctr_counter ctr_i (
                .clk(clk), .rst(rst),
                .inc(src & ~inh_q[i]),
                .wr_lo(sel & ~dec.hi), .wr_hi(sel & dec.hi),
                .wdata(csr_wdata), .value(cnt_q[i])
            );
        end else begin : g_zero
            assign cnt_q[i] = '0;
        end
    end

    always_comb begin
        csr_rdata = '0;
        if (dec.inh)
            csr_rdata = inh_q;
        else if (dec.win && dec.impl)
            csr_rdata = dec.hi ? cnt_q[dec.idx][CW-1:XW] : cnt_q[dec.idx][XW-1:0];
    end

    assign csr_illegal = csr_en & dec.win & ~dec.impl;

endmodule

// File: rtl/mctr_unit_chk.sv
module mctr_unit_chk
    import mctr_pkg::*;
#(
    parameter int NUM_HPM = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              ret_valid,
    input logic              ret_fault,
    input logic              csr_en,
    input logic              csr_we,
    input logic [CSR_AW-1:0] csr_addr,
    input logic [XW-1:0]     csr_wdata,
    input logic [XW-1:0]     csr_rdata,
    input logic              csr_illegal,
    input logic [CW-1:0]     cycle_q,
    input logic [CW-1:0]     instret_q,
    input logic [XW-1:0]     inh_q
);
    localparam logic [XW-1:0] MASK = inhibit_mask(NUM_HPM);

    logic seen;
    always_ff @(posedge clk) seen <= ~rst;

    logic wr_cyc, wr_ir, wr_ir_lo;
    assign wr_cyc   = csr_en && csr_we && (csr_addr == 12'hB00 || csr_addr == 12'hB80);
    assign wr_ir_lo = csr_en && csr_we && (csr_addr == 12'hB02);
    assign wr_ir    = wr_ir_lo || (csr_en && csr_we && csr_addr == 12'hB82);

    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (rst)
        seen && !inh_q[0] && !wr_cyc |=> cycle_q == $past(cycle_q) + 64'd1); // R1

    AST_FAULT_NO_RETIRE: assert property (@(posedge clk) disable iff (rst)
        seen && ret_valid && ret_fault && !wr_ir |=> $stable(instret_q)); // R3

    AST_IR_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        seen && inh_q[2] && !wr_ir |=> $stable(instret_q)); // R2

    AST_WRITE_WINS_LO: assert property (@(posedge clk) disable iff (rst)
        seen && wr_ir_lo |=> instret_q[31:0] == $past(csr_wdata)); // R6

    AST_INHIBIT_READ_LEGAL: assert property (@(posedge clk) disable iff (rst)
        csr_addr == 12'h320 |-> (csr_rdata & ~MASK) == '0); // R8

    AST_ILLEGAL_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        csr_illegal |-> csr_rdata == '0 && csr_en); // R10

endmodule

bind mctr_unit mctr_unit_chk #(.NUM_HPM(NUM_HPM)) chk_i (
    .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_fault(ret_fault),
    .csr_en(csr_en), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
    .cycle_q(cnt_q[0]), .instret_q(cnt_q[2]), .inh_q(inh_q)
);

// File: tb/mctr_unit_tb.sv
`timescale 1ns/1ps
module mctr_unit_tb_top;
    localparam int N = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ret_valid = 1'b0, ret_fault = 1'b0;
    logic [N-1:0] evt = '0;
    logic        csr_en = 1'b0, csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        csr_illegal;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    mctr_unit #(.NUM_HPM(N), .RETIRE_EVT(29'h1)) dut_i (
        .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_fault(ret_fault),
        .evt_i(evt), .csr_en(csr_en), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal)
    );

    // behavioural reference state
    logic [63:0] m_cnt [32];
    logic [31:0] m_inh;

    function automatic bit m_impl(input int i);
        return i == 0 || i == 2 || (i >= 3 && i < 3 + N);
    endfunction

    function automatic bit m_win(input logic [11:0] a);
        return a[11:5] == 7'h58 || a[11:5] == 7'h5C;
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a);
        int i;
        if (a == 12'h320) return m_inh;
        if (!m_win(a)) return 32'h0;
        i = int'(a[4:0]);
        if (!m_impl(i)) return 32'h0;
        return a[7] ? m_cnt[i][63:32] : m_cnt[i][31:0];
    endfunction

    task automatic m_update();
        logic [31:0] inh_old;
        bit clean;
        inh_old = m_inh;
        clean = ret_valid && !ret_fault;
        for (int i = 0; i < 32; i++) begin
            bit inc, wr;
            if (!m_impl(i)) continue;
            inc = (i == 0) ? 1'b1 : (i == 2) ? clean :
                  (i == 3) ? (evt[0] && clean) : evt[i-3];
            wr = csr_en && csr_we && m_win(csr_addr) && int'(csr_addr[4:0]) == i;
            if (rst) m_cnt[i] = 64'h0;
            else if (wr && !csr_addr[7]) m_cnt[i][31:0] = csr_wdata;
            else if (wr) m_cnt[i][63:32] = csr_wdata;
            else if (inc && !inh_old[i]) m_cnt[i] = m_cnt[i] + 64'd1;
        end
        if (rst) m_inh = 32'h0;
        else if (csr_en && csr_we && csr_addr == 12'h320) m_inh = csr_wdata & 32'h0000_003D;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h (addr %h)", tag, act, exp, csr_addr);
        end
    endtask

    // one clock: compare outputs, then let the edge happen
    task automatic cyc(input string tag);
        #1;
        if (!rst) begin
            check(tag, csr_rdata, m_read(csr_addr));
            check(tag, {31'h0, csr_illegal},
                  {31'h0, csr_en && m_win(csr_addr) && !m_impl(int'(csr_addr[4:0]))});
        end
        @(posedge clk);
        m_update();
        @(negedge clk);
    endtask

    task automatic drive(input bit en, input bit we, input logic [11:0] a,
                         input logic [31:0] d, input bit rv, input bit rf,
                         input logic [N-1:0] e);
        csr_en = en; csr_we = we; csr_addr = a; csr_wdata = d;
        ret_valid = rv; ret_fault = rf; evt = e;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) m_cnt[i] = 'x;
        m_inh = 'x;
        @(negedge clk);
        drive(0, 0, 12'h000, 0, 0, 0, '0);
        cyc("R11"); cyc("R11");
        rst = 1'b0;
        // R11: state right after reset
        drive(1, 0, 12'h320, 0, 0, 0, '0); cyc("R11");
        drive(1, 0, 12'hB02, 0, 0, 0, '0); cyc("R11");
        drive(1, 0, 12'hB00, 0, 0, 0, '0); cyc("R1");
        drive(1, 0, 12'hB00, 0, 0, 0, '0); cyc("R1");
        // R2: clean retires
        for (int k = 0; k < 4; k++) begin
            drive(1, 0, 12'hB02, 0, 1, 0, '0); cyc("R2");
        end
        // R3: faulting retires with all events pulsing
        for (int k = 0; k < 3; k++) begin
            drive(1, 0, 12'hB02, 0, 1, 1, 3'b111); cyc("R3");
        end
        drive(1, 0, 12'hB03, 0, 0, 0, '0); cyc("R3");
        drive(1, 0, 12'hB04, 0, 0, 0, '0); cyc("R4");
        // R4: events, with and without retire
        drive(1, 0, 12'hB05, 0, 0, 0, 3'b111); cyc("R4");
        drive(1, 0, 12'hB03, 0, 1, 0, 3'b001); cyc("R4");
        drive(1, 0, 12'hB03, 0, 0, 0, 3'b010); cyc("R4");
        drive(1, 0, 12'hB04, 0, 0, 0, '0); cyc("R4");
        drive(1, 0, 12'hB05, 0, 0, 0, '0); cyc("R4");
        // R6: write low of retire counter while retiring: write wins
        drive(1, 1, 12'hB02, 32'hFFFF_FFFF, 1, 0, '0); cyc("R6");
        drive(1, 0, 12'hB02, 0, 0, 0, '0); cyc("R6");
        drive(1, 0, 12'hB82, 0, 1, 0, '0); cyc("R6");
        // R5: carry landed in the high half
        drive(1, 0, 12'hB82, 0, 0, 0, '0); cyc("R5");
        drive(1, 0, 12'hB02, 0, 0, 0, '0); cyc("R5");
        drive(1, 1, 12'hB80, 32'h1234_5678, 0, 0, '0); cyc("R6");
        drive(1, 0, 12'hB80, 0, 0, 0, '0); cyc("R6");
        drive(1, 0, 12'hB00, 0, 0, 0, '0); cyc("R5");
        // R7, R8: set every inhibit bit while retiring
        drive(1, 1, 12'h320, 32'hFFFF_FFFF, 1, 0, 3'b111); cyc("R7");
        drive(1, 0, 12'h320, 0, 1, 0, 3'b111); cyc("R8");
        drive(1, 0, 12'hB02, 0, 1, 0, 3'b111); cyc("R2");
        drive(1, 0, 12'hB00, 0, 0, 0, '0); cyc("R1");
        drive(1, 0, 12'hB00, 0, 0, 0, '0); cyc("R1");
        drive(1, 0, 12'hB04, 0, 0, 0, 3'b010); cyc("R4");
        // R9: inhibited counter still writable and readable
        drive(1, 1, 12'hB02, 32'h0000_0100, 1, 0, '0); cyc("R9");
        drive(1, 0, 12'hB02, 0, 1, 0, '0); cyc("R9");
        // R7: clear inhibit with a retire in the same cycle: not counted
        drive(1, 1, 12'h320, 32'h0, 1, 0, '0); cyc("R7");
        drive(1, 0, 12'hB02, 0, 1, 0, '0); cyc("R7");
        drive(1, 0, 12'hB02, 0, 0, 0, '0); cyc("R7");
        drive(1, 0, 12'h320, 0, 0, 0, '0); cyc("R8");
        // R10: unimplemented and foreign addresses
        drive(1, 0, 12'hB01, 0, 0, 0, '0); cyc("R10");
        drive(1, 0, 12'hB06, 0, 0, 0, '0); cyc("R10");
        drive(1, 1, 12'hB9F, 32'hDEAD_BEEF, 0, 0, '0); cyc("R10");
        drive(1, 0, 12'h123, 0, 0, 0, '0); cyc("R10");
        drive(0, 0, 12'hB06, 0, 0, 0, '0); cyc("R10");
        drive(1, 0, 12'hB00, 0, 0, 0, '0); cyc("R1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule